// File: doc/BRIEF.md
# Single-Cycle Load/Store Processor Core

This block is a 32-bit processor core that finishes every instruction in one clock cycle. It supports nine instructions: word load, word store, add, subtract, bitwise AND, bitwise OR, signed set-less-than, branch-if-equal and an absolute jump. All state changes (program counter, register file, data memory) happen together on one rising clock edge. Everything in between is combinational: the fetch, the decode, the operand reads, the ALU, the memory read and the next-address choice.

The core holds two internal word arrays. One is a read-only instruction store, read combinationally at the program counter. The other is a data store, written on the clock edge. The testbench fills both arrays before it releases reset. Results are visible at the ports: the program counter, the instruction being executed, the register write-back strobe with its address and data, and the data-store write strobe with its address and data. All of these describe the instruction in flight during the current cycle.

Top module: `sc_core`

## Requirements
- R1: A synchronous active-high reset sets the program counter to 0 and clears all 32 registers on the next rising edge. While reset is high, the register-write and store strobes stay low.
- R2: An instruction that is neither a taken branch nor a jump advances the program counter by exactly 4 on the next edge.
- R3: R-format instructions (opcode 0x00; rs in [25:21], rt in [20:16], rd in [15:11]) write the result to rd. The funct field selects the operation: 0x20 add, 0x22 subtract (rs minus rt), 0x24 AND, 0x25 OR.
- R4: Set-less-than (funct 0x2A) writes 1 to rd when rs is smaller than rt as signed 32-bit values, and 0 otherwise.
- R5: Register 0 always reads as zero, and writes addressed to it leave it zero.
- R6: Word store (opcode 0x2B) raises the store strobe. The address is rs plus the sign-extended 16-bit immediate in [15:0], and the data is rt. A store writes no register.
- R7: Word load (opcode 0x23) writes the data word at rs plus the sign-extended immediate into rt, and the write-back is visible in the same cycle.
- R8: Branch-if-equal (opcode 0x04) sets the next address to PC+4 plus the sign-extended immediate shifted left by two when rs equals rt, and to PC+4 otherwise. It writes neither register nor memory.
- R9: Jump (opcode 0x02) sets the next address to the upper 4 bits of PC+4 joined with the 26-bit index in [25:0] and two zero bits.
- R10: An unlisted opcode, or an R-format instruction with an unlisted funct, writes neither register nor memory and advances the program counter by 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state updates on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| pc_o | output | 32 | Address of the instruction executing this cycle |
| instr_o | output | 32 | Instruction word executing this cycle |
| rf_we_o | output | 1 | Register write-back strobe for this instruction |
| rf_waddr_o | output | 5 | Destination register number |
| rf_wdata_o | output | 32 | Value being written back |
| dm_we_o | output | 1 | Data-store write strobe |
| dm_addr_o | output | 32 | Byte address computed for load/store |
| dm_wdata_o | output | 32 | Word being stored |

## Verification
Set-less-than is tested with a negative operand against a positive one. An unsigned compare would produce the opposite bit there. Branches are tested with both a forward and a backward offset. A design that forgets the sign extension, or the shift by two, lands on the wrong address. A write to register 0 is followed by a read of register 0: a core without the zero guard would return the written value. Unknown opcodes and funct codes are shown to write nothing, and reset is applied while the program counter is nonzero. That reset test also confirms that register contents from the previous program are cleared.

// File: rtl/sc_pkg.sv
package sc_pkg;

    localparam logic [5:0] OPC_RTYPE  = 6'h00;
    localparam logic [5:0] OPC_JUMP   = 6'h02;
    localparam logic [5:0] OPC_BEQ    = 6'h04;
    localparam logic [5:0] OPC_LOADW  = 6'h23;
    localparam logic [5:0] OPC_STOREW = 6'h2B;

    localparam logic [5:0] FN_ADD = 6'h20;
    localparam logic [5:0] FN_SUB = 6'h22;
    localparam logic [5:0] FN_AND = 6'h24;
    localparam logic [5:0] FN_OR  = 6'h25;
    localparam logic [5:0] FN_SLT = 6'h2A;

    typedef enum logic [2:0] {
        ALU_AND = 3'b000,
        ALU_OR  = 3'b001,
        ALU_ADD = 3'b010,
        ALU_SUB = 3'b110,
        ALU_SLT = 3'b111
    } alu_sel_e;

    typedef enum logic [1:0] {
        CLS_ADD   = 2'd0,
        CLS_SUB   = 2'd1,
        CLS_FUNCT = 2'd2
    } alu_class_e;

    typedef struct packed {
        logic       reg_write;
        logic       mem_read;
        logic       mem_write;
        logic       alu_src;
        logic       mem_to_reg;
        logic       reg_dst;
        logic       branch;
        logic       jump;
        alu_class_e alu_class;
    } ctrl_t;

endpackage

// File: rtl/sc_ctrl.sv
module sc_ctrl
    import sc_pkg::*;
(
    input  logic [5:0] opcode,
    input  logic [5:0] funct,
    output ctrl_t      ctl,
    output alu_sel_e   alu_sel
);

    ctrl_t base;
    logic  funct_ok;

    // Main decoder
    always_comb begin
        base = '0;
        case (opcode)
            OPC_RTYPE: begin
                base.reg_write = 1'b1;
                base.reg_dst   = 1'b1;
                base.alu_class = CLS_FUNCT;
            end
            OPC_LOADW: begin
                base.reg_write  = 1'b1;
                base.mem_read   = 1'b1;
                base.alu_src    = 1'b1;
                base.mem_to_reg = 1'b1;
            end
            OPC_STOREW: begin
                base.mem_write = 1'b1;
                base.alu_src   = 1'b1;
            end
            OPC_BEQ: begin
                base.branch    = 1'b1;
                base.alu_class = CLS_SUB;
            end
            OPC_JUMP: base.jump = 1'b1;
            default: base = '0;
        endcase
    end

    // ALU control decoder
    always_comb begin
        alu_sel  = ALU_ADD;
        funct_ok = 1'b1;
        case (base.alu_class)
            CLS_SUB: alu_sel = ALU_SUB;
            CLS_FUNCT: begin
                case (funct)
                    FN_ADD: alu_sel = ALU_ADD;
                    FN_SUB: alu_sel = ALU_SUB;
                    FN_AND: alu_sel = ALU_AND;
                    FN_OR:  alu_sel = ALU_OR;
                    FN_SLT: alu_sel = ALU_SLT;
                    default: funct_ok = 1'b0;
                endcase
            end
            default: alu_sel = ALU_ADD;
        endcase
    end

    // R10: an unlisted funct suppresses the write-back
    always_comb begin
        ctl = base;
        if (!funct_ok) ctl.reg_write = 1'b0;
    end

endmodule

// File: rtl/sc_alu.sv
module sc_alu
    import sc_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  alu_sel_e     sel,
    output logic [W-1:0] y,
    output logic         zero
);

    always_comb begin
        case (sel)
            ALU_AND: y = a & b;
            ALU_OR:  y = a | b;
            ALU_ADD: y = a + b;
            ALU_SUB: y = a - b;
            ALU_SLT: y = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
            default: y = '0;
        endcase
    end

    assign zero = (y == '0);

endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
    parameter int W    = 32,
    parameter int NREG = 32,
    localparam int AW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] ra_a,
    input  logic [AW-1:0] ra_b,
    output logic [W-1:0]  rd_a,
    output logic [W-1:0]  rd_b,
    input  logic          we,
    input  logic [AW-1:0] wa,
    input  logic [W-1:0]  wd
);

    logic [W-1:0] regs_q [NREG];
    logic [W-1:0] regs_d [NREG];

    always_comb begin
        for (int i = 0; i < NREG; i++) regs_d[i] = regs_q[i];
        if (rst) begin
            for (int i = 0; i < NREG; i++) regs_d[i] = '0;
        end else if (we && (wa != '0)) begin
            regs_d[wa] = wd;
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < NREG; i++) regs_q[i] <= regs_d[i];
    end

    assign rd_a = (ra_a == '0) ? '0 : regs_q[ra_a];
    assign rd_b = (ra_b == '0) ? '0 : regs_q[ra_b];

    // R5: a write aimed at register 0 leaves it zero
    a_r5_zero_reg: assert property (@(posedge clk) disable iff (rst)
        (we && wa == '0) |=> (regs_q[0] == '0));

endmodule

// File: rtl/sc_core.sv
module sc_core
    import sc_pkg::*;
#(
    parameter int IMEM_WORDS = 64,
    parameter int DMEM_WORDS = 64
) (
    input  logic        clk,
    input  logic        rst,
    output logic [31:0] pc_o,
    output logic [31:0] instr_o,
    output logic        rf_we_o,
    output logic [4:0]  rf_waddr_o,
    output logic [31:0] rf_wdata_o,
    output logic        dm_we_o,
    output logic [31:0] dm_addr_o,
    output logic [31:0] dm_wdata_o
);

    localparam int IAW = $clog2(IMEM_WORDS);
    localparam int DAW = $clog2(DMEM_WORDS);

    typedef struct packed {
        logic [31:0] pc;
    } state_t;

    state_t state_d, state_q;

    logic [31:0] imem_rom [IMEM_WORDS];
    logic [31:0] dmem_q   [DMEM_WORDS];

    initial begin
        for (int i = 0; i < IMEM_WORDS; i++) imem_rom[i] = '0;
    end

    logic [31:0] instr;
    ctrl_t       ctl;
    alu_sel_e    alu_sel;
    logic [31:0] rs_val, rt_val, imm_ext, alu_b, alu_y;
    logic        alu_zero;
    logic [31:0] seq_pc, br_pc, jmp_pc, mem_rd, wb_data;
    logic [4:0]  wb_addr;
    logic        take_br, rf_we, dm_we;
    logic [DAW-1:0] dm_idx;

    // Fetch
    assign instr  = imem_rom[state_q.pc[IAW+1:2]];
    assign seq_pc = state_q.pc + 32'd4;

    // Decode
    sc_ctrl u_ctrl (
        .opcode  (instr[31:26]),
        .funct   (instr[5:0]),
        .ctl     (ctl),
        .alu_sel (alu_sel)
    );

    sc_regfile #(.W(32), .NREG(32)) u_rf (
        .clk  (clk),
        .rst  (rst),
        .ra_a (instr[25:21]),
        .ra_b (instr[20:16]),
        .rd_a (rs_val),
        .rd_b (rt_val),
        .we   (rf_we),
        .wa   (wb_addr),
        .wd   (wb_data)
    );

    // Execute
    assign imm_ext = {{16{instr[15]}}, instr[15:0]};
    assign alu_b   = ctl.alu_src ? imm_ext : rt_val;

    sc_alu #(.W(32)) u_alu (
        .a    (rs_val),
        .b    (alu_b),
        .sel  (alu_sel),
        .y    (alu_y),
        .zero (alu_zero)
    );

    // Next address candidates
    assign br_pc   = seq_pc + {imm_ext[29:0], 2'b00};
    assign jmp_pc  = {seq_pc[31:28], instr[25:0], 2'b00};
    assign take_br = ctl.branch & alu_zero;

    // Memory and write-back
    assign dm_idx  = alu_y[DAW+1:2];
    assign mem_rd  = ctl.mem_read ? dmem_q[dm_idx] : '0;
    assign wb_data = ctl.mem_to_reg ? mem_rd : alu_y;
    assign wb_addr = ctl.reg_dst ? instr[15:11] : instr[20:16];
    assign rf_we   = ctl.reg_write & ~rst;
    assign dm_we   = ctl.mem_write & ~rst;

    always_comb begin
        state_d = state_q;
        if (rst)           state_d.pc = '0;
        else if (ctl.jump) state_d.pc = jmp_pc;
        else if (take_br)  state_d.pc = br_pc;
        else               state_d.pc = seq_pc;
    end

    always_ff @(posedge clk) begin
        state_q <= state_d;
        if (dm_we) dmem_q[dm_idx] <= rt_val;
    end

    assign pc_o       = state_q.pc;
    assign instr_o    = instr;
    assign rf_we_o    = rf_we;
    assign rf_waddr_o = wb_addr;
    assign rf_wdata_o = wb_data;
    assign dm_we_o    = dm_we;
    assign dm_addr_o  = alu_y;
    assign dm_wdata_o = rt_val;

    // R1: reset lands the program counter at zero
    a_r1_pc_reset: assert property (@(posedge clk)
        rst |=> (state_q.pc == '0));

    // R2: plain instructions step by one word
    a_r2_seq_step: assert property (@(posedge clk) disable iff (rst)
        (!ctl.jump && !ctl.branch) |=> (state_q.pc == $past(state_q.pc) + 32'd4));

    // R8: a taken branch implies equal register operands
    a_r8_branch_equal: assert property (@(posedge clk) disable iff (rst)
        take_br |-> (rs_val == rt_val));

    // R9: a jump lands on the index in the low 28 bits
    a_r9_jump_target: assert property (@(posedge clk) disable iff (rst)
        ctl.jump |=> (state_q.pc[27:0] == {$past(instr[25:0]), 2'b00}));

    // R6: a store never also writes a register
    a_r6_store_no_wb: assert property (@(posedge clk) disable iff (rst)
        dm_we |-> !rf_we);

endmodule

// File: tb/sc_core_bench.sv
module sc_core_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] pc_o, instr_o, rf_wdata_o, dm_addr_o, dm_wdata_o;
    logic        rf_we_o, dm_we_o;
    logic [4:0]  rf_waddr_o;

    int nvec = 0;
    int nerr = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    sc_core u_sc_core (
        .clk        (clk),
        .rst        (rst),
        .pc_o       (pc_o),
        .instr_o    (instr_o),
        .rf_we_o    (rf_we_o),
        .rf_waddr_o (rf_waddr_o),
        .rf_wdata_o (rf_wdata_o),
        .dm_we_o    (dm_we_o),
        .dm_addr_o  (dm_addr_o),
        .dm_wdata_o (dm_wdata_o)
    );

    function automatic logic [31:0] rfmt(input int rs, input int rt, input int rd, input logic [5:0] fn);
        return {6'h00, rs[4:0], rt[4:0], rd[4:0], 5'd0, fn};
    endfunction

    function automatic logic [31:0] ifmt(input logic [5:0] op, input int rs, input int rt, input int imm);
        return {op, rs[4:0], rt[4:0], imm[15:0]};
    endfunction

    function automatic logic [31:0] jfmt(input int idx);
        return {6'h02, idx[25:0]};
    endfunction

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        nvec++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic chk_wb(input string req, input int addr, input logic [31:0] data);
        chk(req, "rf_we", {31'd0, rf_we_o}, 32'd1);
        chk(req, "rf_waddr", {27'd0, rf_waddr_o}, addr);
        chk(req, "rf_wdata", rf_wdata_o, data);
    endtask

    task automatic chk_quiet(input string req);
        chk(req, "rf_we", {31'd0, rf_we_o}, 32'd0);
        chk(req, "dm_we", {31'd0, dm_we_o}, 32'd0);
    endtask

    // Holds reset, clears the program, preloads data; returns just after one edge
    task automatic begin_prog();
        rst = 1'b1;
        for (int i = 0; i < 64; i++) u_sc_core.imem_rom[i] = 32'd0;
        u_sc_core.dmem_q[0] = 32'd5;
        u_sc_core.dmem_q[1] = 32'd7;
        u_sc_core.dmem_q[2] = 32'hFFFF_FFF0;
        u_sc_core.dmem_q[3] = 32'd32;
        @(posedge clk);
        #1;
    endtask

    task automatic release_rst();
        @(negedge clk);
        rst = 1'b0;
        #1;
    endtask

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic t_arith();
        begin_prog();
        u_sc_core.imem_rom[0]  = ifmt(6'h23, 0, 1, 0);
        u_sc_core.imem_rom[1]  = ifmt(6'h23, 0, 2, 4);
        u_sc_core.imem_rom[2]  = ifmt(6'h23, 0, 3, 8);
        u_sc_core.imem_rom[3]  = rfmt(1, 2, 4, 6'h20);
        u_sc_core.imem_rom[4]  = rfmt(1, 2, 5, 6'h22);
        u_sc_core.imem_rom[5]  = rfmt(1, 2, 6, 6'h24);
        u_sc_core.imem_rom[6]  = rfmt(1, 3, 7, 6'h25);
        u_sc_core.imem_rom[7]  = rfmt(3, 1, 8, 6'h2A);
        u_sc_core.imem_rom[8]  = rfmt(1, 3, 9, 6'h2A);
        u_sc_core.imem_rom[9]  = rfmt(1, 1, 10, 6'h2A);
        release_rst();
        chk("R7", "pc", pc_o, 32'd0);
        chk_wb("R7", 1, 32'd5);
        step(); chk("R2", "pc", pc_o, 32'd4); chk_wb("R7", 2, 32'd7);
        step(); chk_wb("R7", 3, 32'hFFFF_FFF0);
        step(); chk("R2", "pc", pc_o, 32'd12); chk_wb("R3 add", 4, 32'd12);
        step(); chk_wb("R3 sub", 5, 32'hFFFF_FFFE);
        step(); chk_wb("R3 and", 6, 32'd5);
        step(); chk_wb("R3 or", 7, 32'hFFFF_FFF5);
        step(); chk_wb("R4 neg<pos", 8, 32'd1);
        step(); chk_wb("R4 pos<neg", 9, 32'd0);
        step(); chk_wb("R4 equal", 10, 32'd0);
        chk("R2", "pc", pc_o, 32'd36);
    endtask

    task automatic t_reset();
        // program counter is nonzero when reset is raised
        begin_prog();
        chk("R1", "pc after one edge", pc_o, 32'd0);
        u_sc_core.imem_rom[0] = ifmt(6'h2B, 0, 1, 8);
        u_sc_core.imem_rom[1] = ifmt(6'h23, 0, 2, 0);
        u_sc_core.imem_rom[2] = rfmt(4, 4, 3, 6'h20);
        @(negedge clk); #1;
        chk("R1", "pc held", pc_o, 32'd0);
        chk_quiet("R1 gated in reset");
        release_rst();
        chk("R6", "dm_we", {31'd0, dm_we_o}, 32'd1);
        chk("R6", "dm_addr", dm_addr_o, 32'd8);
        chk("R6", "dm_wdata", dm_wdata_o, 32'd0);
        chk("R6", "rf_we", {31'd0, rf_we_o}, 32'd0);
        step(); chk("R2", "pc", pc_o, 32'd4); chk_wb("R7", 2, 32'd5);
        step(); chk_wb("R1 regs cleared", 3, 32'd0);
    endtask

    task automatic t_store_zero();
        begin_prog();
        u_sc_core.imem_rom[0] = ifmt(6'h23, 0, 1, 0);
        u_sc_core.imem_rom[1] = ifmt(6'h23, 0, 3, 12);
        u_sc_core.imem_rom[2] = rfmt(1, 1, 0, 6'h20);
        u_sc_core.imem_rom[3] = rfmt(0, 1, 2, 6'h20);
        u_sc_core.imem_rom[4] = ifmt(6'h2B, 3, 1, -8);
        u_sc_core.imem_rom[5] = ifmt(6'h23, 0, 4, 24);
        u_sc_core.imem_rom[6] = {6'h3F, 5'd1, 5'd2, 16'h0010};
        u_sc_core.imem_rom[7] = rfmt(1, 1, 5, 6'h3F);
        u_sc_core.imem_rom[8] = rfmt(1, 0, 6, 6'h20);
        release_rst();
        step(); chk_wb("R7", 3, 32'd32);
        step();
        step(); chk_wb("R5 r0 reads zero", 2, 32'd5);
        step();
        chk("R6 neg offset", "dm_we", {31'd0, dm_we_o}, 32'd1);
        chk("R6 neg offset", "dm_addr", dm_addr_o, 32'd24);
        chk("R6 neg offset", "dm_wdata", dm_wdata_o, 32'd5);
        step(); chk_wb("R7 reads stored word", 4, 32'd5);
        step(); chk("R10", "pc", pc_o, 32'd24); chk_quiet("R10 bad opcode");
        step(); chk("R10", "pc", pc_o, 32'd28); chk_quiet("R10 bad funct");
        step(); chk("R10", "pc after", pc_o, 32'd32); chk_wb("R5 r0 still zero", 6, 32'd5);
    endtask

    task automatic t_branch();
        begin_prog();
        u_sc_core.imem_rom[0]  = ifmt(6'h23, 0, 1, 0);
        u_sc_core.imem_rom[1]  = ifmt(6'h23, 0, 2, 0);
        u_sc_core.imem_rom[2]  = ifmt(6'h23, 0, 3, 4);
        u_sc_core.imem_rom[3]  = ifmt(6'h04, 1, 3, 5);
        u_sc_core.imem_rom[4]  = ifmt(6'h04, 1, 2, 3);
        u_sc_core.imem_rom[8]  = ifmt(6'h04, 0, 0, -3);
        u_sc_core.imem_rom[6]  = jfmt(12);
        u_sc_core.imem_rom[12] = rfmt(1, 2, 7, 6'h20);
        release_rst();
        step(); step(); step();
        chk("R8", "pc at beq", pc_o, 32'd12); chk_quiet("R8 no writes");
        step(); chk("R8 not taken", "pc", pc_o, 32'd16);
        step(); chk("R8 forward", "pc", pc_o, 32'd32);
        step(); chk("R8 backward", "pc", pc_o, 32'd24); chk_quiet("R9 no writes");
        step(); chk("R9 jump", "pc", pc_o, 32'd48);
        chk_wb("R9 lands", 7, 32'd10);
    endtask

    initial begin
        #(20 * 100000);
        if (!done) begin
            nvec++;
            nerr++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
            $finish;
        end
    end

    initial begin
        t_arith();
        t_reset();
        t_store_zero();
        t_branch();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end

endmodule